// File: doc/BRIEF.md
# LDPC Edge Permutation Index Generator

This block builds the routing tables that an iterative message-passing LDPC decoder needs. Each edge is a nonzero of a sparse parity-check matrix. The block links two orderings of those edges. The check order is row-major: edges sorted by row, then by column. The bit order is column-major: edges sorted by column, then by row.

A build starts with a `start` pulse that carries the column weight W and the edge count E. The edges then arrive one per cycle as (row, column) pairs, in check order. For each edge the block computes four things:

- its column rank, from a counter kept per column;
- its bit-order position, from a closed-form formula;
- the inverse entry, which maps a bit-order position back to a check-order position;
- a flag that marks the start of a new row.

A final scan over the bit-ordered table marks where each new column starts. When the scan ends, `done` pulses and every table can be read by address through a combinational read port. All indices are 0-based and all ranks are 1-based.

The control is a four-state machine:

- IDLE goes to LOAD on `start` (a start with E = 0 goes straight to FINISH).
- LOAD goes to SCAN when the E-th edge is accepted.
- SCAN goes to FINISH after it has visited E bit-order positions.
- FINISH always goes to IDLE after one cycle.

Top module: `ldpc_edge_permuter`

## Requirements
- R1: After reset, `busy`, `done` and `err` are all 0.
- R2: A `start` seen in IDLE captures `cfg_wcol` and `cfg_edges` and raises `busy`. After the last edge has been accepted and the scan has finished, `done` is high for exactly one cycle while `busy` is still high. `busy` is low on the following cycle.
- R3: The column rank of the edge at check-order position p is read as `rd_rank` at `rd_addr` = p. It equals 1 plus the number of earlier-arriving edges in the same column, so within a column the edge that arrives first has rank 1.
- R4: `rd_bit_idx` at check-order position p equals col·W + (rank − 1), where col is that edge's 0-based column.
- R5: `rd_chk_idx` at bit-order position b equals the check-order position p whose bit index is b. It is the exact inverse of the R4 table.
- R6: `rd_chk_seg` at check-order position p is 1 when p = 0, or when that edge's row differs from the row of the edge at p − 1. Otherwise it is 0.
- R7: `rd_bit_seg` at bit-order position b is 1 when b = 0, or when the column of the edge at b differs from the column of the edge at b − 1. Otherwise it is 0.
- R8: `err` goes to 1 after a build in either of two cases: an edge arrives in a column that already holds W edges, or `cfg_wcol` is 0 or larger than MAX_W. `err` stays set until the next accepted `start` clears it.
- R9: `edge_valid` has no effect outside LOAD, and `start` has no effect while `busy` is high. In either case the tables keep the values of the last build.
- R10: For the 3×6 matrix with W = 2 whose rows hold columns {0,2,3,5}, {1,2,4,5} and {0,1,3,4}, the inverse table reads 0 8 4 9 1 5 2 10 6 11 3 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a build when the block is idle |
| cfg_wcol | input | $clog2(MAX_W+1) | Column weight W, captured on start |
| cfg_edges | input | $clog2(MAX_E+1) | Edge count E, captured on start |
| edge_valid | input | 1 | Edge present this cycle |
| edge_row | input | $clog2(MAX_ROWS) | 0-based row of the edge |
| edge_col | input | $clog2(MAX_COLS) | 0-based column of the edge |
| rd_addr | input | $clog2(MAX_E) | Table read address |
| rd_bit_idx | output | $clog2(MAX_E) | Bit-order index of check-order entry rd_addr |
| rd_chk_idx | output | $clog2(MAX_E) | Check-order index of bit-order entry rd_addr |
| rd_rank | output | $clog2(MAX_W+1) | Column rank of check-order entry rd_addr |
| rd_chk_seg | output | 1 | Row-start flag of check-order entry rd_addr |
| rd_bit_seg | output | 1 | Column-start flag of bit-order entry rd_addr |
| busy | output | 1 | A build is in progress |
| done | output | 1 | One-cycle pulse: tables complete |
| err | output | 1 | Column-weight violation in the last build |

## Verification
The bench targets these corner cases, and what a faulty design would show in each:

- **W = 1.** A rank counter that never starts at 1 would shift every bit index.
- **W = MAX_W with a full 64-entry table.** A design that truncates the index arithmetic would wrap `rd_bit_idx` and break the inverse table.
- **Random matrices with uneven row lengths.** These expose a row-start flag that compares the wrong neighbour, and a column-start scan that is off by one position.
- **An overloaded column, a zero weight, and edges or starts sent while busy or idle.** A design without the weight check would leave `err` low. A design that accepts stray input would overwrite entries from the previous build.

// File: rtl/epi_pkg.sv
package epi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SCAN,
        ST_FIN
    } epi_state_t;

endpackage

// File: rtl/epi_rank_bank.sv
module epi_rank_bank #(
    parameter int MAX_COLS = 32,
    parameter int MAX_W    = 4,
    localparam int CLW     = $clog2(MAX_COLS),
    localparam int WW      = $clog2(MAX_W + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           inc,
    input  logic [CLW-1:0] col,
    input  logic [WW-1:0]  wcol,
    output logic [WW-1:0]  rank,
    output logic           full
);

    logic [WW-1:0] cnt_w [MAX_COLS];

    for (genvar g = 0; g < MAX_COLS; g++) begin : g_col
        logic [WW-1:0] c_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                c_q <= '0;
            end else if (clr) begin
                c_q <= '0;
            end else if (inc && (col == CLW'(g)) && (c_q < wcol)) begin
                c_q <= c_q + 1'b1;
            end
        end

        assign cnt_w[g] = c_q;

        // R3: a per-column occurrence count never passes the column weight
        assert_counter_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            c_q <= wcol);
    end

    always_comb begin
        rank = cnt_w[col] + 1'b1;
        full = (cnt_w[col] >= wcol);
    end

endmodule

// File: rtl/epi_tables.sv
module epi_tables #(
    parameter int MAX_E    = 64,
    parameter int MAX_COLS = 32,
    parameter int MAX_W    = 4,
    localparam int IW      = $clog2(MAX_E),
    localparam int CLW     = $clog2(MAX_COLS),
    localparam int WW      = $clog2(MAX_W + 1)
) (
    input  logic           clk,
    // check-order write, one per accepted edge
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_pos,
    input  logic [IW-1:0]  wr_bit_idx,
    input  logic [WW-1:0]  wr_rank,
    input  logic           wr_chk_seg,
    // bit-order write of the inverse entry
    input  logic           inv_en,
    input  logic [CLW-1:0] inv_col,
    // column-start flag write during the scan
    input  logic           seg_en,
    input  logic [IW-1:0]  seg_pos,
    input  logic           seg_val,
    // scan read taps
    input  logic [IW-1:0]  sc_addr,
    input  logic [IW-1:0]  sc_prev_addr,
    output logic [CLW-1:0] sc_col_cur,
    output logic [CLW-1:0] sc_col_prev,
    output logic [IW-1:0]  sc_back,
    // external read port
    input  logic [IW-1:0]  rd_addr,
    output logic [IW-1:0]  rd_bit_idx,
    output logic [IW-1:0]  rd_chk_idx,
    output logic [WW-1:0]  rd_rank,
    output logic           rd_chk_seg,
    output logic           rd_bit_seg
);

    logic [IW-1:0]  bit_tbl     [MAX_E];
    logic [WW-1:0]  rank_tbl    [MAX_E];
    logic [IW-1:0]  chk_tbl     [MAX_E];
    logic [CLW-1:0] col_by_bit  [MAX_E];
    logic [MAX_E-1:0] chk_seg_tbl;
    logic [MAX_E-1:0] bit_seg_tbl;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            bit_tbl[wr_pos]     <= wr_bit_idx;
            rank_tbl[wr_pos]    <= wr_rank;
            chk_seg_tbl[wr_pos] <= wr_chk_seg;
        end
        if (inv_en) begin
            chk_tbl[wr_bit_idx]    <= wr_pos;
            col_by_bit[wr_bit_idx] <= inv_col;
        end
        if (seg_en) begin
            bit_seg_tbl[seg_pos] <= seg_val;
        end
    end

    always_comb begin
        sc_col_cur  = col_by_bit[sc_addr];
        sc_col_prev = col_by_bit[sc_prev_addr];
        sc_back     = bit_tbl[chk_tbl[sc_addr]];
        rd_bit_idx  = bit_tbl[rd_addr];
        rd_chk_idx  = chk_tbl[rd_addr];
        rd_rank     = rank_tbl[rd_addr];
        rd_chk_seg  = chk_seg_tbl[rd_addr];
        rd_bit_seg  = bit_seg_tbl[rd_addr];
    end

endmodule

// File: rtl/ldpc_edge_permuter.sv
module ldpc_edge_permuter
    import epi_pkg::*;
#(
    parameter int MAX_E    = 64,
    parameter int MAX_COLS = 32,
    parameter int MAX_ROWS = 32,
    parameter int MAX_W    = 4,
    localparam int IW      = $clog2(MAX_E),
    localparam int EW      = $clog2(MAX_E + 1),
    localparam int CLW     = $clog2(MAX_COLS),
    localparam int RW      = $clog2(MAX_ROWS),
    localparam int WW      = $clog2(MAX_W + 1),
    localparam int PW      = CLW + WW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [WW-1:0]  cfg_wcol,
    input  logic [EW-1:0]  cfg_edges,
    input  logic           edge_valid,
    input  logic [RW-1:0]  edge_row,
    input  logic [CLW-1:0] edge_col,
    input  logic [IW-1:0]  rd_addr,
    output logic [IW-1:0]  rd_bit_idx,
    output logic [IW-1:0]  rd_chk_idx,
    output logic [WW-1:0]  rd_rank,
    output logic           rd_chk_seg,
    output logic           rd_bit_seg,
    output logic           busy,
    output logic           done,
    output logic           err
);

    epi_state_t state_q, state_d;

    logic [WW-1:0]  wcol_q;
    logic [EW-1:0]  edges_q;
    logic [EW-1:0]  pos_q;
    logic [EW-1:0]  scan_q;
    logic [RW-1:0]  prev_row_q;
    logic           err_q;

    logic           start_acc;
    logic           accept;
    logic           last_edge;
    logic           last_scan;
    logic [WW-1:0]  rank;
    logic           col_full;
    logic [PW-1:0]  bit_calc;
    logic           bit_ok;
    logic           chk_seg_val;
    logic [IW-1:0]  scan_addr;
    logic [IW-1:0]  scan_prev;
    logic [CLW-1:0] sc_col_cur;
    logic [CLW-1:0] sc_col_prev;
    logic [IW-1:0]  sc_back;
    logic           bit_seg_val;

    assign start_acc = (state_q == ST_IDLE) && start;
    assign accept    = (state_q == ST_LOAD) && edge_valid;
    assign last_edge = (pos_q == edges_q - EW'(1));
    assign last_scan = (scan_q == edges_q - EW'(1));

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (cfg_edges == '0) ? ST_FIN : ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (accept && last_edge) begin
                    state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (last_scan) begin
                    state_d = ST_FIN;
                end
            end
            ST_FIN: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy = 1'b1;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_LOAD: busy = 1'b1;
            ST_SCAN: busy = 1'b1;
            ST_FIN:  done = 1'b1;
            default: busy = 1'b0;
        endcase
        err = err_q;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcol_q     <= '0;
            edges_q    <= '0;
            pos_q      <= '0;
            scan_q     <= '0;
            prev_row_q <= '0;
            err_q      <= 1'b0;
        end else begin
            if (start_acc) begin
                wcol_q  <= cfg_wcol;
                edges_q <= cfg_edges;
                pos_q   <= '0;
                scan_q  <= '0;
                err_q   <= (cfg_wcol == '0) || (cfg_wcol > WW'(MAX_W));
            end
            if (accept) begin
                pos_q      <= pos_q + EW'(1);
                prev_row_q <= edge_row;
                if (!bit_ok) begin
                    err_q <= 1'b1;
                end
            end
            if (state_q == ST_SCAN) begin
                scan_q <= scan_q + EW'(1);
            end
        end
    end

    // ---------------- rank and index ----------------
    epi_rank_bank #(
        .MAX_COLS (MAX_COLS),
        .MAX_W    (MAX_W)
    ) u_rank (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_acc),
        .inc   (accept),
        .col   (edge_col),
        .wcol  (wcol_q),
        .rank  (rank),
        .full  (col_full)
    );

    always_comb begin
        bit_calc    = PW'(edge_col) * PW'(wcol_q) + PW'(rank) - PW'(1);
        bit_ok      = !col_full && (bit_calc < PW'(edges_q));
        chk_seg_val = (pos_q == '0) || (edge_row != prev_row_q);
        scan_addr   = scan_q[IW-1:0];
        scan_prev   = scan_addr - IW'(1);
        bit_seg_val = (scan_q == '0) || (sc_col_cur != sc_col_prev);
    end

    epi_tables #(
        .MAX_E    (MAX_E),
        .MAX_COLS (MAX_COLS),
        .MAX_W    (MAX_W)
    ) u_tables (
        .clk          (clk),
        .wr_en        (accept),
        .wr_pos       (pos_q[IW-1:0]),
        .wr_bit_idx   (bit_calc[IW-1:0]),
        .wr_rank      (rank),
        .wr_chk_seg   (chk_seg_val),
        .inv_en       (accept && bit_ok),
        .inv_col      (edge_col),
        .seg_en       (state_q == ST_SCAN),
        .seg_pos      (scan_addr),
        .seg_val      (bit_seg_val),
        .sc_addr      (scan_addr),
        .sc_prev_addr (scan_prev),
        .sc_col_cur   (sc_col_cur),
        .sc_col_prev  (sc_col_prev),
        .sc_back      (sc_back),
        .rd_addr      (rd_addr),
        .rd_bit_idx   (rd_bit_idx),
        .rd_chk_idx   (rd_chk_idx),
        .rd_rank      (rd_rank),
        .rd_chk_seg   (rd_chk_seg),
        .rd_bit_seg   (rd_bit_seg)
    );

    // ---------------- assertions ----------------
    // R2: done lasts one cycle
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: the scan only leaves toward FINISH
    assert_scan_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |=> (state_q == ST_SCAN) || (state_q == ST_FIN));

    // R5: on a clean build the bit table undoes the inverse table at every scanned slot
    assert_inverse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) && !err_q |-> (sc_back == scan_addr));

    // R8: err is held until a new build is accepted
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !start_acc |=> err_q);

    // R9: a start while busy leaves the captured weight untouched
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) && start |=> $stable(wcol_q));

endmodule

// File: tb/ldpc_edge_permuter_test.sv
`timescale 1ns/1ps
module ldpc_edge_permuter_test;

    localparam int MAX_E = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] cfg_wcol = '0;
    logic [6:0] cfg_edges = '0;
    logic       edge_valid = 1'b0;
    logic [4:0] edge_row = '0;
    logic [4:0] edge_col = '0;
    logic [5:0] rd_addr = '0;
    logic [5:0] rd_bit_idx, rd_chk_idx;
    logic [2:0] rd_rank;
    logic       rd_chk_seg, rd_bit_seg, busy, done, err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int er [MAX_E];
    int ec [MAX_E];
    int ne;
    int erank [MAX_E];
    int ebit  [MAX_E];
    int echk  [MAX_E];
    int ecs   [MAX_E];
    int ebs   [MAX_E];

    always #2.5 clk = ~clk;

    ldpc_edge_permuter uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_wcol(cfg_wcol),
        .cfg_edges(cfg_edges), .edge_valid(edge_valid), .edge_row(edge_row),
        .edge_col(edge_col), .rd_addr(rd_addr), .rd_bit_idx(rd_bit_idx),
        .rd_chk_idx(rd_chk_idx), .rd_rank(rd_rank), .rd_chk_seg(rd_chk_seg),
        .rd_bit_seg(rd_bit_seg), .busy(busy), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void compute_expected(input int w);
        int colbit [MAX_E];
        for (int p = 0; p < ne; p++) begin
            int r = 1;
            for (int q = 0; q < p; q++) if (ec[q] == ec[p]) r++;
            erank[p] = r;
            ebit[p]  = ec[p] * w + r - 1;
            echk[ebit[p]] = p;
            colbit[ebit[p]] = ec[p];
            ecs[p] = (p == 0 || er[p] != er[p-1]) ? 1 : 0;
        end
        for (int b = 0; b < ne; b++)
            ebs[b] = (b == 0 || colbit[b] != colbit[b-1]) ? 1 : 0;
    endfunction

    task automatic random_matrix(input int m, input int n, input int w);
        bit hm [32][32];
        for (int r = 0; r < 32; r++) for (int c = 0; c < 32; c++) hm[r][c] = 1'b0;
        for (int c = 0; c < n; c++) begin
            int placed = 0;
            while (placed < w) begin
                int r = int'($urandom % m);
                if (!hm[r][c]) begin hm[r][c] = 1'b1; placed++; end
            end
        end
        ne = 0;
        for (int r = 0; r < m; r++) for (int c = 0; c < n; c++)
            if (hm[r][c]) begin er[ne] = r; ec[ne] = c; ne++; end
    endtask

    // returns 1 if done arrived; junk drives stray edges and starts while busy
    task automatic run_build(input int w, input int e, input bit junk, output bit got);
        int cyc = 0;
        @(negedge clk);
        start = 1'b1; cfg_wcol = 3'(w); cfg_edges = 7'(e);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        for (int p = 0; p < e; p++) begin
            edge_valid = 1'b1; edge_row = 5'(er[p]); edge_col = 5'(ec[p]);
            @(negedge clk);
        end
        edge_valid = 1'b0;
        got = 1'b0;
        while (!got && cyc < 500) begin
            if (done) begin
                got = 1'b1;
            end else begin
                if (junk) begin
                    edge_valid = 1'b1; start = 1'b1; cfg_wcol = 3'd1;
                    edge_row = 5'($urandom % 32); edge_col = 5'($urandom % 32);
                end
                @(negedge clk);
                cyc++;
            end
        end
        edge_valid = 1'b0; start = 1'b0; cfg_wcol = 3'(w);
        check(got, "R2 done pulse seen", int'(got), 1);
        if (got) begin
            check(busy == 1'b1, "R2 busy high with done", int'(busy), 1);
            @(negedge clk);
            check(done == 1'b0, "R2 done lasts one cycle", int'(done), 0);
            check(busy == 1'b0, "R2 busy low after done", int'(busy), 0);
        end
    endtask

    task automatic check_tables(input string tag);
        for (int a = 0; a < ne; a++) begin
            rd_addr = 6'(a);
            #1;
            check(int'(rd_rank) == erank[a], {"R3 rank ", tag}, int'(rd_rank), erank[a]);
            check(int'(rd_bit_idx) == ebit[a], {"R4 bit index ", tag}, int'(rd_bit_idx), ebit[a]);
            check(int'(rd_chk_idx) == echk[a], {"R5 inverse index ", tag}, int'(rd_chk_idx), echk[a]);
            check(int'(rd_chk_seg) == ecs[a], {"R6 row start ", tag}, int'(rd_chk_seg), ecs[a]);
            check(int'(rd_bit_seg) == ebs[a], {"R7 column start ", tag}, int'(rd_bit_seg), ebs[a]);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit got;
        int ref10 [12];
        void'($urandom(32'd20240));
        ref10 = '{0, 8, 4, 9, 1, 5, 2, 10, 6, 11, 3, 7};

        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
        check(done == 1'b0, "R1 done at reset", int'(done), 0);
        check(err == 1'b0, "R1 err at reset", int'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: directed 3x6 W=2 example
        begin
            int rows [3][4];
            rows = '{'{0, 2, 3, 5}, '{1, 2, 4, 5}, '{0, 1, 3, 4}};
            ne = 0;
            for (int r = 0; r < 3; r++) for (int k = 0; k < 4; k++) begin
                er[ne] = r; ec[ne] = rows[r][k]; ne++;
            end
        end
        compute_expected(2);
        run_build(2, ne, 1'b0, got);
        check(err == 1'b0, "R8 err clear on valid build", int'(err), 0);
        for (int a = 0; a < 12; a++) begin
            rd_addr = 6'(a);
            #1;
            check(int'(rd_chk_idx) == ref10[a], "R10 known inverse table", int'(rd_chk_idx), ref10[a]);
        end
        check_tables("example");

        // R9: stray edges while idle change nothing
        repeat (6) begin
            @(negedge clk);
            edge_valid = 1'b1; edge_row = 5'($urandom % 32); edge_col = 5'($urandom % 32);
        end
        @(negedge clk);
        edge_valid = 1'b0;
        check(busy == 1'b0, "R9 idle edges do not start a build", int'(busy), 0);
        check_tables("R9 after idle edges");

        // corner: W=1
        random_matrix(5, 12, 1);
        compute_expected(1);
        run_build(1, ne, 1'b0, got);
        check_tables("W1");

        // corner: W=MAX, 64 edges, stray input during build (R9)
        random_matrix(9, 16, 4);
        compute_expected(4);
        run_build(4, ne, 1'b1, got);
        check(err == 1'b0, "R9 stray start during build", int'(err), 0);
        check_tables("W4 full with stray input R9");

        // random builds
        for (int t = 0; t < 8; t++) begin
            int w = 1 + int'($urandom % 4);
            int n = 1 + int'($urandom % (64 / w));
            int m = w + int'($urandom % 8);
            random_matrix(m, n, w);
            compute_expected(w);
            run_build(w, ne, t[0], got);
            check(err == 1'b0, "R8 no err on random build", int'(err), 0);
            check_tables("random");
        end

        // R8: overloaded column
        ne = 4;
        er[0] = 0; ec[0] = 0;
        er[1] = 1; ec[1] = 0;
        er[2] = 2; ec[2] = 0;
        er[3] = 2; ec[3] = 1;
        run_build(2, 4, 1'b0, got);
        check(err == 1'b1, "R8 overloaded column sets err", int'(err), 1);
        repeat (3) @(negedge clk);
        check(err == 1'b1, "R8 err held while idle", int'(err), 1);

        // R8: zero weight
        run_build(0, 4, 1'b0, got);
        check(err == 1'b1, "R8 zero weight sets err", int'(err), 1);

        // R8: a clean build clears err
        random_matrix(4, 6, 2);
        compute_expected(2);
        run_build(2, ne, 1'b0, got);
        check(err == 1'b0, "R8 new start clears err", int'(err), 0);
        check_tables("after error");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule